// File: doc/BRIEF.md
# Correlator Integration Timer and Register Window

This block is the control side of a sixteen-slice correlator that hangs off a microprocessor bus. It keeps a programmable integration length and counts sampling-clock cycles against it. At the end of each period it sends one single-cycle capture strobe to all slices, so that each slice copies its accumulated count into its buffer and starts again from zero. In the same cycle it raises a data-ready flag for the processor.

The processor sees the block as a window of 32 words, each 16 bits wide, selected by a 5-bit address. The slice buffers sit at the bottom of this window, with the length, control and status words just above them. The length is counted in steps of 2^STEP_LOG2 sampling cycles. The length field is LEN_W bits wide, and a stored value of zero selects the largest length, 2^LEN_W steps. With the default parameters this gives steps of 256 cycles and a longest period of 2^24 cycles.

The bus carries no data stream, so it has no valid/ready pair and no back-pressure. A read or a write completes in the cycle its strobe is high. Read data is combinational from the address.

Top module: `xcorr_ctrl`

## Requirements
- R1: After reset, capture_strobe and data_ready are 0, and the words at addresses 16, 17 and 18 read 0.
- R2: A read of address i, for i from 0 to 15, returns slice word i in the same cycle. Slice word i is taken from bits [16*i+15:16*i] of slice_bufs.
- R3: Address 16 is the length word. It stores the low LEN_W bits of the written data and reads back with zeros above them. A period lasts length × 2^STEP_LOG2 cycles, and a stored length of 0 means 2^LEN_W steps.
- R4: Bit 0 of address 17 is run enable. A write of 1 to it at clock edge E produces the first strobe in the cycle that follows edge E+P, where P is the period in cycles. After that the strobe repeats every P cycles.
- R5: capture_strobe is high for exactly one cycle at a time. It stays low for as long as run is disabled.
- R6: data_ready, which also reads back as bit 0 of address 18, becomes 1 in the same cycle as the strobe.
- R7: data_ready clears after a read (bus_rd) of any slice address 0 to 15, or after a write with bit 0 set to address 18. A write of 0 leaves it unchanged. A strobe in the same cycle as a clear wins.
- R8: A length written while running does not change the period in progress. The new length applies from the next period boundary.
- R9: A length written while run is disabled applies at once, so the first period after enable uses it.
- R10: Reads of addresses 19 to 31 return 0. Writes to addresses 0 to 15 and 19 to 31 change no readable state.
- R11: Clearing run resets the cycle count. After run is enabled again, the first strobe comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_rd | input | 1 | Read strobe; needed only for the flag clear |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data for bus_addr |
| slice_bufs | input | NUM_SLICES*WORD_W | Buffered slice counts, slice 0 in the low bits |
| capture_strobe | output | 1 | One-cycle end-of-period strobe to all slices |
| data_ready | output | 1 | New results available |

## Verification
The bench builds the block with LEN_W = 4 and STEP_LOG2 = 2. Steps are then 4 cycles long and the longest period is 64 cycles. These values keep the zero-means-maximum length and the truncation of wide writes within a short run. The same logic as the 2^24-cycle default is exercised. The tests measure the exact cycle distance between strobes across length changes made while running and while stopped, across a stop and restart in mid-period, and across the different ways the ready flag is cleared.

// File: rtl/xcorr_ctrl_pkg.sv
package xcorr_ctrl_pkg;
  localparam int unsigned REG_LEN  = 16;
  localparam int unsigned REG_CTRL = 17;
  localparam int unsigned REG_STAT = 18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SLICE,
    SEL_LEN,
    SEL_CTRL,
    SEL_STAT
  } win_sel_e;
endpackage

// File: rtl/xcorr_period_timer.sv
module xcorr_period_timer #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned STEP_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] len_prog,
  output logic             wrap_now,
  output logic             strobe,
  output logic [LEN_W-1:0] len_active
);
  localparam int unsigned CNT_W = LEN_W + STEP_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] units_m1;
  logic [CNT_W-1:0] last;

  // zero length wraps to all ones: 2^LEN_W steps
  assign units_m1 = len_active - LEN_W'(1);
  assign last     = {units_m1, {STEP_LOG2{1'b1}}};
  assign wrap_now = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      strobe     <= 1'b0;
      len_active <= '0;
    end else if (!run) begin
      cnt        <= '0;
      strobe     <= 1'b0;
      len_active <= len_prog;
    end else if (wrap_now) begin
      cnt        <= '0;
      strobe     <= 1'b1;
      len_active <= len_prog;
    end else begin
      cnt        <= cnt + CNT_W'(1);
      strobe     <= 1'b0;
    end
  end
endmodule

// File: rtl/xcorr_ready_flag.sv
module xcorr_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic ready
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ready <= 1'b0;
    else if (set_i) ready <= 1'b1;
    else if (clr_i) ready <= 1'b0;
  end
endmodule

// File: rtl/xcorr_bus_regs.sv
module xcorr_bus_regs
  import xcorr_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 16,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned LEN_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic [WORD_W-1:0]            bus_wdata,
  input  logic [NUM_SLICES*WORD_W-1:0] slice_bufs,
  input  logic                         ready,
  output logic [WORD_W-1:0]            bus_rdata,
  output logic [LEN_W-1:0]             len_reg,
  output logic                         run_q,
  output logic                         ready_clr
);
  localparam int unsigned SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  logic [WORD_W-1:0] slice_w [NUM_SLICES];
  win_sel_e          sel;

  genvar g;
  generate
    for (g = 0; g < NUM_SLICES; g++) begin : g_slice
      assign slice_w[g] = slice_bufs[g*WORD_W +: WORD_W];
    end
  endgenerate

  always_comb begin
    if (bus_addr < ADDR_W'(NUM_SLICES))        sel = SEL_SLICE;
    else if (bus_addr == ADDR_W'(REG_LEN))     sel = SEL_LEN;
    else if (bus_addr == ADDR_W'(REG_CTRL))    sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(REG_STAT))    sel = SEL_STAT;
    else                                       sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_SLICE: bus_rdata = slice_w[bus_addr[SEL_W-1:0]];
      SEL_LEN:   bus_rdata = WORD_W'(len_reg);
      SEL_CTRL:  bus_rdata = WORD_W'(run_q);
      SEL_STAT:  bus_rdata = WORD_W'(ready);
      default:   bus_rdata = '0;
    endcase
  end

  assign ready_clr = (bus_rd && sel == SEL_SLICE) ||
                     (bus_wr && sel == SEL_STAT && bus_wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_reg <= '0;
      run_q   <= 1'b0;
    end else if (bus_wr) begin
      if (sel == SEL_LEN)  len_reg <= bus_wdata[LEN_W-1:0];
      if (sel == SEL_CTRL) run_q   <= bus_wdata[0];
    end
  end
endmodule

// File: rtl/xcorr_ctrl.sv
module xcorr_ctrl #(
  parameter int unsigned NUM_SLICES = 16,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned STEP_LOG2  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic [WORD_W-1:0]            bus_rdata,
  input  logic [NUM_SLICES*WORD_W-1:0] slice_bufs,
  output logic                         capture_strobe,
  output logic                         data_ready
);
  logic [LEN_W-1:0] len_reg;
  logic [LEN_W-1:0] len_active;
  logic             run_q;
  logic             wrap_now;
  logic             ready_clr;

  xcorr_bus_regs #(
    .NUM_SLICES(NUM_SLICES), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .slice_bufs(slice_bufs),
    .ready(data_ready), .bus_rdata(bus_rdata), .len_reg(len_reg),
    .run_q(run_q), .ready_clr(ready_clr)
  );

  xcorr_period_timer #(.LEN_W(LEN_W), .STEP_LOG2(STEP_LOG2)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .len_prog(len_reg),
    .wrap_now(wrap_now), .strobe(capture_strobe), .len_active(len_active)
  );

  xcorr_ready_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set_i(wrap_now), .clr_i(ready_clr),
    .ready(data_ready)
  );
endmodule

// File: rtl/xcorr_ctrl_chk.sv
module xcorr_ctrl_chk #(
  parameter int unsigned NUM_SLICES = 16,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned LEN_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              capture_strobe,
  input logic              data_ready,
  input logic              run_q,
  input logic [LEN_W-1:0]  len_active
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_strobe |=> !capture_strobe);  // R5

  AST_NO_STROBE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $past(!run_q)) |-> !capture_strobe);  // R5

  AST_READY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_strobe |-> data_ready);  // R6

  AST_READY_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> capture_strobe);  // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr < ADDR_W'(NUM_SLICES)) |=> (!data_ready || capture_strobe));  // R7

  AST_LEN_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !capture_strobe) |-> $stable(len_active));  // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(18)) |-> (bus_rdata == '0));  // R10
endmodule

bind xcorr_ctrl xcorr_ctrl_chk #(
  .NUM_SLICES(NUM_SLICES), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .capture_strobe(capture_strobe),
  .data_ready(data_ready), .run_q(run_q), .len_active(len_active)
);

// File: tb/xcorr_ctrl_tb_top.sv
module xcorr_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NS = 16;
  localparam int WW = 16;
  localparam int STEP = 4;   // 2^STEP_LOG2 with STEP_LOG2 = 2

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      bus_addr = '0;
  logic            bus_rd = 1'b0;
  logic            bus_wr = 1'b0;
  logic [WW-1:0]   bus_wdata = '0;
  logic [WW-1:0]   bus_rdata;
  logic [NS*WW-1:0] slice_bufs;
  logic            capture_strobe;
  logic            data_ready;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  xcorr_ctrl #(.LEN_W(4), .STEP_LOG2(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slice_bufs(slice_bufs), .capture_strobe(capture_strobe),
    .data_ready(data_ready)
  );

  function automatic logic [WW-1:0] slice_val(int i);
    return 16'hA000 + 16'(i * 16'h0111);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(int a, output int d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic rd_pulse(int a, output int d);
    @(negedge clk);
    bus_addr = 5'(a); bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // counts negedges until capture_strobe is seen high
  task automatic wait_strobe(output int n);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      n++;
      if (capture_strobe) return;
    end
    n = -1;
  endtask

  task automatic t_reset();
    int d;
    chk("R1 strobe", capture_strobe, 0);
    chk("R1 ready", data_ready, 0);
    peek(16, d); chk("R1 len", d, 0);
    peek(17, d); chk("R1 ctrl", d, 0);
    peek(18, d); chk("R1 stat", d, 0);
  endtask

  task automatic t_slices();
    int d;
    for (int i = 0; i < NS; i += 5) begin
      peek(i, d); chk("R2 slice read", d, int'(slice_val(i)));
    end
    peek(15, d); chk("R2 slice 15", d, int'(slice_val(15)));
  endtask

  task automatic t_unused();
    int d;
    peek(19, d); chk("R10 read 19", d, 0);
    peek(31, d); chk("R10 read 31", d, 0);
    wr(3, 16'hFFFF); wr(25, 16'hFFFF); wr(19, 16'hFFFF);
    peek(3, d);  chk("R10 slice unchanged", d, int'(slice_val(3)));
    peek(16, d); chk("R10 len unchanged", d, 0);
    peek(17, d); chk("R10 ctrl unchanged", d, 0);
    peek(18, d); chk("R10 stat unchanged", d, 0);
    chk("R10 no strobe", capture_strobe, 0);
  endtask

  task automatic t_period();
    int d, n;
    wr(16, 16'h00F3);
    peek(16, d); chk("R3 len truncated", d, 3);
    wr(17, 1);
    wait_strobe(n); chk("R4 first strobe", n, 3*STEP);
    chk("R6 ready with strobe", data_ready, 1);
    @(negedge clk); chk("R5 strobe width", capture_strobe, 0);
    wait_strobe(n); chk("R4 repeat period", n, 3*STEP - 1);
    @(negedge clk); chk("R5 strobe width 2", capture_strobe, 0);
    peek(18, d); chk("R6 status bit", d, 1);
  endtask

  task automatic t_ready_clear();
    int d, n;
    wr(18, 0);
    chk("R7 write 0 keeps", data_ready, 1);
    rd_pulse(5, d);
    chk("R7 slice read clears", data_ready, 0);
    wait_strobe(n);
    chk("R7 set again", data_ready, 1);
    wr(18, 1);
    chk("R7 w1c clears", data_ready, 0);
  endtask

  task automatic t_len_running();
    int n;
    wait_strobe(n);
    wr(16, 5);
    wait_strobe(n); chk("R8 old period kept", n, 3*STEP - 2);
    wait_strobe(n); chk("R8 new period", n, 5*STEP);
  endtask

  task automatic t_len_stopped();
    int n, quiet;
    wr(17, 0);
    wr(16, 2);
    wr(17, 1);
    wait_strobe(n); chk("R9 immediate length", n, 2*STEP);
    repeat (3) @(negedge clk);
    wr(17, 0);
    quiet = 0;
    repeat (20) begin
      @(negedge clk);
      if (capture_strobe) quiet++;
    end
    chk("R5 no strobe stopped", quiet, 0);
    wr(17, 1);
    wait_strobe(n); chk("R11 full period after restart", n, 2*STEP);
  endtask

  task automatic t_zero_len();
    int n;
    wr(17, 0);
    wr(16, 0);
    wr(17, 1);
    wait_strobe(n); chk("R3 zero means max", n, 16*STEP);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) slice_bufs[i*WW +: WW] = slice_val(i);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slices();
    t_unused();
    t_period();
    t_ready_clear();
    t_len_running();
    t_len_stopped();
    t_zero_len();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule